// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a memory-mapped general-purpose I/O port. Every pin has three settings: a data latch, a direction bit and a pullup-enable bit. A small register bus reaches all three. From these settings the block drives output-enable, output-value and pullup-enable signals to the pad models. It also samples the pin levels through a two-stage synchroniser.

Reset clears the direction and pullup settings, but the data latch keeps its contents. Software can therefore load output values before any pin is turned into an output, and those values survive a reset pulse.

A read of the data register is assembled bit by bit. An input bit returns the synchronised pin level and an output bit returns the latch. One pin, chosen by a parameter, is input-only: its output driver never turns on, whatever its direction bit holds.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 1 asserts `pin_oe` for that pin from the cycle after the write. A direction bit of 0 deasserts it.
- R2: While `rst_n` is low and right after reset:
  - every direction bit and every pullup-enable bit is 0;
  - `pin_oe`, `pin_pu` and `bus_rdata` are all zero.
- R3: The data latch holds its value through a reset pulse. After reset, setting the direction bits to 1 again drives the old value and reads it back.
- R4: A read at offset 0 returns, per bit, the synchronised pin level where the direction bit is 0 and the latch bit where it is 1.
- R5: A write at offset 0 updates the latch even for input pins. `pin_out` carries the latch bit only while that pin's `pin_oe` is 1, and is 0 otherwise.
- R6: `pin_pu` for a pin is 1 only when its pullup-enable bit is 1 and its direction bit is 0.
- R7: The input-only pin (index `RO_PIN`, default 2, active when `RO_EN` is 1) never asserts `pin_oe`, even when its direction bit is 1.
- R8: Offset 1 (direction) and offset 2 (pullup enable) read back exactly the value last written.
- R9: Offset 3 reads as zero. A write to offset 3 changes no register.
- R10: `bus_rdata` is registered: it shows the addressed register one cycle after the address is presented. The value returned is the one held before a write issued in that same cycle.
- R11: A pin level change reaches a data read after two synchroniser stages. With the address held at 0, the new level appears in `bus_rdata` after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin levels from pads |
| pin_oe | output | WIDTH | Per-pin output driver enable |
| pin_out | output | WIDTH | Per-pin output value |
| pin_pu | output | WIDTH | Per-pin pullup enable |

## Verification
The hardest case to reach is a data latch that survives reset. It is only visible after reset if a value was stored before reset and the pins are switched back to output afterwards. The stimulus therefore does this in order:
1. Loads a distinctive pattern into the latch.
2. Drives it out.
3. Pulses reset.
4. Confirms that direction and pullup read back zero.
5. Re-enables the outputs and expects the old pattern on both `pin_out` and the data read.

Mixed-direction reads are covered by splitting the port between inputs and outputs. The synchroniser delay is covered by a pin change timed against a held data address. A long random phase then follows, with the model compared on every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = async_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stage2;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q
);
    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] pull;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [WIDTH-1:0] data_d, data_q;

    // Next-state for the reset-cleared configuration registers.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_DIR:  cfg_d.dir  = wr_data;
                SEL_PULL: cfg_d.pull = wr_data;
                default:  ;
            endcase
        end
    end

    // Next-state for the data latch; written regardless of direction.
    always_comb begin
        data_d = data_q;
        if (wr_en && (wr_sel == SEL_DATA)) begin
            data_d = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // Intentionally without reset: contents persist across reset.
    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign latch_q = data_q;
    assign dir_q   = cfg_q.dir;
    assign pull_q  = cfg_q.pull;
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl #(
    parameter int WIDTH  = 8,
    parameter int RO_PIN = 2,
    parameter bit RO_EN  = 1'b1
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] pull,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] out,
    output logic [WIDTH-1:0] pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (RO_EN && (i == RO_PIN)) begin : g_in_only
            assign oe[i] = 1'b0;
        end else begin : g_bidir
            assign oe[i] = dir[i];
        end
        assign out[i] = oe[i] ? latch[i] : 1'b0;
        assign pu[i]  = pull[i] & ~dir[i];
    end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         rd_sel,
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] pull,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] rdata_d, rdata_q;
    logic [WIDTH-1:0] data_view;

    // Per bit: output pins show the latch, input pins show the pin.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            data_view[i] = dir[i] ? latch[i] : pin_sync[i];
        end
    end

    always_comb begin
        rdata_d = '0;
        case (rd_sel)
            SEL_DATA: rdata_d = data_view;
            SEL_DIR:  rdata_d = dir;
            SEL_PULL: rdata_d = pull;
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int RO_PIN = 2,
    parameter bit RO_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_pu
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] latch_w, dir_w, pull_w, sync_w;

    assign sel = reg_sel_e'(bus_addr);

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_w)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .latch_q (latch_w),
        .dir_q   (dir_w),
        .pull_q  (pull_w)
    );

    gpio_padctl #(.WIDTH(WIDTH), .RO_PIN(RO_PIN), .RO_EN(RO_EN)) u_pad (
        .latch (latch_w),
        .dir   (dir_w),
        .pull  (pull_w),
        .oe    (pin_oe),
        .out   (pin_out),
        .pu    (pin_pu)
    );

    gpio_rdmux #(.WIDTH(WIDTH)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_sel   (sel),
        .latch    (latch_w),
        .dir      (dir_w),
        .pull     (pull_w),
        .pin_sync (sync_w),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH  = 8,
    parameter int RO_PIN = 2,
    parameter bit RO_EN  = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_we,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_pu
);
    localparam logic [WIDTH-1:0] OE_MASK =
        (RO_EN && RO_PIN < WIDTH) ? ~(WIDTH'(1) << RO_PIN) : '1;

    // R1
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd1) |=> (pin_oe == ($past(bus_wdata) & OE_MASK)));

    // R7
    ro_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~OE_MASK) == '0);

    // R2
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && pin_pu == '0));

    // R6
    pull_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_we && bus_addr == 2'd0) && $stable(pin_oe)) |-> $stable(pin_out));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |=> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .RO_PIN(RO_PIN), .RO_EN(RO_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_pu    (pin_pu)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int RO         = 2;
    localparam logic [W-1:0] MASK = ~(8'(1) << RO);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_oe, pin_out, pin_pu;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [W-1:0] m_data = '0;
    logic [W-1:0] m_dir  = '0;
    logic [W-1:0] m_pu   = '0;
    logic [W-1:0] m_s1   = '0;
    logic [W-1:0] m_s2   = '0;
    logic [W-1:0] m_rd   = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port #(.WIDTH(W), .RO_PIN(RO), .RO_EN(1'b1)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .pin_pu    (pin_pu)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir = '0; m_pu = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
        end else begin
            logic [W-1:0] nr;
            case (bus_addr)
                2'd0: nr = (m_dir & m_data) | (~m_dir & m_s2);
                2'd1: nr = m_dir;
                2'd2: nr = m_pu;
                default: nr = '0;
            endcase
            if (bus_we) begin
                case (bus_addr)
                    2'd0: m_data = bus_wdata;
                    2'd1: m_dir  = bus_wdata;
                    2'd2: m_pu   = bus_wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
            m_rd = nr;
        end
    end

    task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R4/R8/R10 rdata model", bus_rdata, m_rd);
            cmp("R1/R7 oe model", pin_oe, m_dir & MASK);
            cmp("R5 out model", pin_out, m_dir & MASK & m_data);
            cmp("R6 pu model", pin_pu, m_pu & ~m_dir);
        end
    end

    task automatic step(logic [1:0] a, logic w, logic [W-1:0] d);
        bus_addr = a; bus_we = w; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        pin_in = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(2'd1, 1'b0, '0);
        // R2 reset state
        cmp("R2 rdata", bus_rdata, 8'h00);
        cmp("R2 oe", pin_oe, 8'h00);
        cmp("R2 pu", pin_pu, 8'h00);
        // R5 latch write on input pins, not driven
        step(2'd0, 1'b1, 8'hA5);
        cmp("R5 out while input", pin_out, 8'h00);
        step(2'd0, 1'b0, '0);
        cmp("R4 input read", bus_rdata, 8'h3C);
        // R1 / R7 drive all
        step(2'd1, 1'b1, 8'hFF);
        cmp("R1 oe", pin_oe, 8'hFB);
        cmp("R7 ro pin", pin_oe[RO], 1'b0);
        cmp("R5 out", pin_out, 8'hA1);
        step(2'd0, 1'b0, '0);
        cmp("R4 output read", bus_rdata, 8'hA5);
        step(2'd1, 1'b0, '0);
        cmp("R8 dir read", bus_rdata, 8'hFF);
        // R6 pullup gating
        step(2'd2, 1'b1, 8'hFF);
        step(2'd1, 1'b1, 8'h0F);
        cmp("R6 pu", pin_pu, 8'hF0);
        step(2'd2, 1'b0, '0);
        cmp("R8 pull read", bus_rdata, 8'hFF);
        step(2'd0, 1'b0, '0);
        cmp("R4 mixed read", bus_rdata, 8'h35);
        // R9 unmapped
        step(2'd3, 1'b1, 8'h77);
        step(2'd3, 1'b0, '0);
        cmp("R9 unmapped read", bus_rdata, 8'h00);
        step(2'd1, 1'b0, '0);
        cmp("R9 dir untouched", bus_rdata, 8'h0F);
        step(2'd2, 1'b0, '0);
        cmp("R9 pull untouched", bus_rdata, 8'hFF);
        // R10 read-before-write
        step(2'd1, 1'b1, 8'h55);
        cmp("R10 old value", bus_rdata, 8'h0F);
        step(2'd1, 1'b0, '0);
        cmp("R10 new value", bus_rdata, 8'h55);
        // R11 synchroniser latency
        step(2'd1, 1'b1, 8'h00);
        step(2'd0, 1'b0, '0);
        bus_addr = 2'd0; pin_in = 8'hC3;
        repeat (2) @(negedge clk);
        cmp("R11 not yet", bus_rdata, 8'h3C);
        @(negedge clk);
        cmp("R11 arrived", bus_rdata, 8'hC3);
        // R3 latch survives reset
        step(2'd0, 1'b1, 8'h5A);
        step(2'd1, 1'b1, 8'hFF);
        pulse_reset();
        step(2'd1, 1'b0, '0);
        cmp("R2 dir cleared", bus_rdata, 8'h00);
        step(2'd2, 1'b0, '0);
        cmp("R2 pull cleared", bus_rdata, 8'h00);
        cmp("R2 oe after reset", pin_oe, 8'h00);
        step(2'd1, 1'b1, 8'hFF);
        cmp("R3 out kept", pin_out, 8'h5A);
        step(2'd0, 1'b0, '0);
        cmp("R3 read kept", bus_rdata, 8'h5A);
        // Random phase, model compared each clock
        for (int k = 0; k < 400; k++) begin
            pin_in = 8'($urandom);
            step(2'($urandom), 1'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule